// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block sits on the host side of an 8-bit converter that has a parallel result bus. On a trigger request it pulls the active-low conversion-start line low for a set number of cycles. It then waits for the converter's end-of-conversion line to fall. That line rests high and is passed through a two-flop synchronizer before any edge is detected. Once the fall is seen, the block drives chip-select and read low together for a set number of cycles. It samples the data bus on the last cycle of that window and then raises both strobes again.

The captured byte is presented with a data-valid flag, which also serves as the interrupt-style completion signal. The byte and the flag are held until the consumer asserts ready. Triggers that arrive while a conversion or a hold is in progress are dropped, not queued. A freshly powered converter holds end-of-conversion low, so only a high-to-low transition seen while waiting counts as completion. A low level at reset never does. If no such transition arrives within a set number of cycles, the block raises a timeout error and goes back to idle. The error stays up until the next trigger is accepted.

Top module: `adc_pbus_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cnv_n_o, cs_n_o and rd_n_o are driven to 1, and dvalid_o and tmo_err_o are 0. cnv_n_o is never undefined.
- R2: A trig_i sampled high in the idle state drives cnv_n_o low from the next cycle for exactly CNV_LOW_CYC cycles. The same acceptance clears tmo_err_o from that cycle on.
- R3: Completion is accepted only on a high-to-low transition of eoc_i that the synchronizer sees while waiting. cs_n_o falls exactly 3 cycles after eoc_i falls (two synchronizer flops plus the state register). An eoc_i that is low at reset, or that falls while the block is idle, never starts a read.
- R4: cs_n_o and rd_n_o are low together for exactly RD_LOW_CYC cycles per conversion, and never while cnv_n_o is low.
- R5: dout_o takes the value data_i had in the last cycle of the read window, the cycle just before the strobes rise.
- R6: dvalid_o goes high in the cycle after the read window and stays high with dout_o unchanged until dready_i is sampled high. It is low in the next cycle.
- R7: trig_i has no effect while the block is not idle, including during the data hold. No cnv_n_o pulse follows, and no trigger is kept for later.
- R8: If no accepted eoc_i fall occurs within TMO_CYC cycles after the start pulse ends, tmo_err_o goes high, the block returns to idle without a read, and tmo_err_o stays high until the next accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Conversion request, sampled in idle |
| eoc_i | input | 1 | End-of-conversion from converter, asynchronous, idles high |
| data_i | input | DW | Parallel result bus from converter |
| dready_i | input | 1 | Consumer accepts the held byte |
| cnv_n_o | output | 1 | Active-low conversion-start strobe |
| cs_n_o | output | 1 | Active-low chip-select |
| rd_n_o | output | 1 | Active-low read strobe |
| dout_o | output | DW | Captured byte |
| dvalid_o | output | 1 | Captured byte valid / completion flag |
| tmo_err_o | output | 1 | End-of-conversion timeout error |

## Verification
All 256 byte values go through the full start, wait, read and hold sequence. The delay before end-of-conversion and the hold length vary with the value, which shows whether any timing depends on how long the wait or the hold lasts. During each read window the bus value changes every cycle, so a byte captured on the wrong cycle gives a different value. This separates sampling on the last cycle from sampling on an earlier one. End-of-conversion held low from reset, and a fall that happens while idle, must both end in a timeout of exact length and never in a read. Triggers sent during waiting and holding must produce no start pulse, now or later.

// File: rtl/adc_pbus_pkg.sv
package adc_pbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_READ  = 3'd3,
    ST_HOLD  = 3'd4
  } ctrl_state_e;

  // True on the final cycle of a phase lasting len cycles
  function automatic bit phase_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Value the bench places on the bus in read-window cycle idx
  function automatic logic [7:0] bus_pattern(input logic [7:0] base, input int unsigned idx);
    return base + idx[7:0];
  endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // Flops reset low so that a line resting low after power-up makes no edge
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else        sh_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else        sh_q[g] <= sh_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign level_o = sh_q[STAGES-1];
  assign fall_o  = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/adc_pbus_ctrl.sv
module adc_pbus_ctrl #(
  parameter int DW          = 8,
  parameter int CNV_LOW_CYC = 4,
  parameter int RD_LOW_CYC  = 4,
  parameter int TMO_CYC     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          eoc_i,
  input  logic [DW-1:0] data_i,
  input  logic          dready_i,
  output logic          cnv_n_o,
  output logic          cs_n_o,
  output logic          rd_n_o,
  output logic [DW-1:0] dout_o,
  output logic          dvalid_o,
  output logic          tmo_err_o
);
  import adc_pbus_pkg::*;

  localparam int unsigned LONGEST = max3(CNV_LOW_CYC, RD_LOW_CYC, TMO_CYC);
  localparam int CW = $clog2(LONGEST) + 1;

  ctrl_state_e   state_q, state_d;
  logic [CW-1:0] cnt;
  logic          eoc_lvl;
  logic          eoc_fall;

  // Named internal events
  logic in_idle, in_start, in_wait, in_read, in_hold;
  logic trig_acc, start_done, tmo_hit, eoc_acc, rd_done, release_ev;
  logic timer_clr;
  logic tmo_q;

  adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (eoc_i),
    .level_o (eoc_lvl),
    .fall_o  (eoc_fall)
  );

  assign in_idle  = (state_q == ST_IDLE);
  assign in_start = (state_q == ST_START);
  assign in_wait  = (state_q == ST_WAIT);
  assign in_read  = (state_q == ST_READ);
  assign in_hold  = (state_q == ST_HOLD);

  assign trig_acc   = in_idle & trig_i;
  assign start_done = in_start & phase_last(32'(cnt), CNV_LOW_CYC);
  assign eoc_acc    = in_wait & eoc_fall;
  assign tmo_hit    = in_wait & ~eoc_fall & phase_last(32'(cnt), TMO_CYC);
  assign rd_done    = in_read & phase_last(32'(cnt), RD_LOW_CYC);
  assign release_ev = in_hold & dready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (trig_acc)   state_d = ST_START;
      ST_START: if (start_done) state_d = ST_WAIT;
      ST_WAIT: begin
        if (eoc_acc)      state_d = ST_READ;
        else if (tmo_hit) state_d = ST_IDLE;
      end
      ST_READ:  if (rd_done)    state_d = ST_HOLD;
      ST_HOLD:  if (release_ev) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Counter restarts on every phase change and rests at zero in idle and hold
  assign timer_clr = (state_d != state_q) | in_idle | in_hold;

  adc_phase_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (timer_clr),
    .cnt_o (cnt)
  );

  adc_result_reg #(.DW(DW)) u_result (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (rd_done),
    .d_i   (data_i),
    .q_o   (dout_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmo_q <= 1'b0;
    else if (trig_acc) tmo_q <= 1'b0;
    else if (tmo_hit)  tmo_q <= 1'b1;
  end

  // Strobes decode straight from the state register
  assign cnv_n_o   = ~in_start;
  assign cs_n_o    = ~in_read;
  assign rd_n_o    = ~in_read;
  assign dvalid_o  = in_hold;
  assign tmo_err_o = tmo_q;

  logic unused_lvl;
  assign unused_lvl = eoc_lvl;
endmodule

// File: rtl/adc_pbus_ctrl_chk.sv
module adc_pbus_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] data_i,
  input logic          dready_i,
  input logic          cnv_n_o,
  input logic          cs_n_o,
  input logic          rd_n_o,
  input logic [DW-1:0] dout_o,
  input logic          dvalid_o,
  input logic          tmo_err_o,
  input logic          eoc_fall,
  input logic          in_wait,
  input logic          trig_acc
);
  AST_START_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cnv_n_o && (!cs_n_o || !rd_n_o))); // R4

  AST_READ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(eoc_fall)); // R3

  AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid_o) |-> (dout_o == $past(data_i)) && $past(!rd_n_o)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o && !dready_i |=> dvalid_o && $stable(dout_o)); // R6

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o && dready_i |=> !dvalid_o); // R6

  AST_NO_START_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o |=> cnv_n_o); // R7

  AST_TMO_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> $past(in_wait) && cs_n_o); // R8

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o && trig_acc |=> !tmo_err_o); // R8
endmodule

bind adc_pbus_ctrl adc_pbus_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/adc_pbus_ctrl_bench.sv
module adc_pbus_ctrl_bench;
  localparam int DW  = 8;
  localparam int CNV = 2;
  localparam int RDL = 3;
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_i = 1'b0;
  logic          eoc_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          dready_i = 1'b0;
  logic          cnv_n_o, cs_n_o, rd_n_o, dvalid_o, tmo_err_o;
  logic [DW-1:0] dout_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_pbus_ctrl #(
    .DW(DW), .CNV_LOW_CYC(CNV), .RD_LOW_CYC(RDL), .TMO_CYC(TMO), .SYNC_STAGES(2)
  ) u_adc_pbus_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .eoc_i(eoc_i), .data_i(data_i),
    .dready_i(dready_i), .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
    .dout_o(dout_o), .dvalid_o(dvalid_o), .tmo_err_o(tmo_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_idle_outputs(input string req);
    check(cnv_n_o === 1'b1, req, int'(cnv_n_o), 1);
    check(cs_n_o === 1'b1 && rd_n_o === 1'b1, req, int'({cs_n_o, rd_n_o}), 3);
    check(dvalid_o === 1'b0, req, int'(dvalid_o), 0);
  endtask

  // One full conversion; the converter is modelled procedurally
  task automatic run_conv(input logic [7:0] val, input int dly, input int hold_cyc);
    int w;
    int lat;
    int r;
    logic [7:0] expv;
    logic [7:0] held;
    trig_i = 1'b1;
    tick();
    trig_i = 1'b0;
    check(tmo_err_o === 1'b0, "R8 clear on trigger", int'(tmo_err_o), 0);
    w = 0;
    while (cnv_n_o == 1'b0 && w < 50) begin
      w++;
      tick();
    end
    check(w == CNV, "R2 start width", w, CNV);
    for (int i = 0; i < dly; i++) begin
      trig_i = (i == 0);
      tick();
      trig_i = 1'b0;
      check(cnv_n_o === 1'b1, "R7 trigger in wait", int'(cnv_n_o), 1);
      check(cs_n_o === 1'b1, "R3 no read before edge", int'(cs_n_o), 1);
    end
    eoc_i = 1'b0;
    lat = 0;
    do begin
      tick();
      lat++;
    end while (cs_n_o == 1'b1 && lat < 50);
    check(lat == 3, "R3 edge to read latency", lat, 3);
    r = 0;
    while (cs_n_o == 1'b0 && r < 50) begin
      check(rd_n_o === 1'b0 && cnv_n_o === 1'b1, "R4 strobes", int'({cnv_n_o, rd_n_o}), 2);
      data_i = adc_pbus_pkg::bus_pattern(val, r);
      r++;
      tick();
    end
    check(r == RDL, "R4 read width", r, RDL);
    eoc_i = 1'b1;
    data_i = ~val;
    expv = adc_pbus_pkg::bus_pattern(val, RDL - 1);
    check(dvalid_o === 1'b1, "R6 valid after read", int'(dvalid_o), 1);
    check(dout_o == expv, "R5 captured byte", int'(dout_o), int'(expv));
    held = dout_o;
    for (int i = 0; i < hold_cyc; i++) begin
      trig_i = 1'b1;
      data_i = val ^ 8'h5A;
      tick();
      check(dvalid_o === 1'b1 && dout_o == held, "R6 hold", int'(dout_o), int'(held));
      check(cnv_n_o === 1'b1, "R7 trigger in hold", int'(cnv_n_o), 1);
    end
    trig_i = 1'b0;
    dready_i = 1'b1;
    tick();
    dready_i = 1'b0;
    check(dvalid_o === 1'b0, "R6 release", int'(dvalid_o), 0);
    tick();
    check(cnv_n_o === 1'b1, "R7 no queued trigger", int'(cnv_n_o), 1);
  endtask

  // Trigger with no end-of-conversion fall: expect an exact-length timeout
  task automatic run_tmo(input string tag);
    int w;
    int n;
    bit rd_seen;
    trig_i = 1'b1;
    tick();
    trig_i = 1'b0;
    w = 0;
    while (cnv_n_o == 1'b0 && w < 50) begin
      w++;
      tick();
    end
    check(w == CNV, "R2 start width", w, CNV);
    n = 0;
    rd_seen = 1'b0;
    while (tmo_err_o == 1'b0 && n < 100) begin
      if (cs_n_o == 1'b0) rd_seen = 1'b1;
      tick();
      n++;
    end
    check(n == TMO, {"R8 timeout length ", tag}, n, TMO);
    check(!rd_seen && cs_n_o === 1'b1, {"R3 no false completion ", tag}, int'(rd_seen), 0);
    check(dvalid_o === 1'b0, "R8 no data on timeout", int'(dvalid_o), 0);
    for (int i = 0; i < 4; i++) tick();
    check(tmo_err_o === 1'b1 && cnv_n_o === 1'b1, "R8 error held in idle", int'(tmo_err_o), 1);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      nerr++;
      nvec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    // R1: converter powered down, end-of-conversion low across reset
    eoc_i = 1'b0;
    repeat (3) tick();
    check(cnv_n_o === 1'b1, "R1 start defined in reset", int'(cnv_n_o), 1);
    check_idle_outputs("R1 reset");
    check(tmo_err_o === 1'b0, "R1 reset error", int'(tmo_err_o), 0);
    rst_n = 1'b1;
    tick();
    check_idle_outputs("R1 after reset");
    repeat (3) tick();
    run_tmo("low since reset");
    eoc_i = 1'b1;
    repeat (4) tick();
    // Fall while idle must be discarded
    eoc_i = 1'b0;
    repeat (5) tick();
    check_idle_outputs("R3 idle fall ignored");
    run_tmo("idle fall");
    eoc_i = 1'b1;
    repeat (4) tick();
    for (int v = 0; v < 256; v++) begin
      run_conv(v[7:0], 1 + (v % 7), v % 3);
    end
    run_tmo("after sweep");
    run_conv(8'hA5, 2, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule